// File: doc/BRIEF.md
# Operand Swizzle and Masked Lane Writeback

This block conditions operands and results for a vector datapath with 64-bit registers. Each register is seen as four 16-bit lanes called x, y, z and w, with x in the most significant position. For each of two source operands, every output lane independently takes any source lane or a forced zero, as a 12-bit swizzle code chosen per operand directs. Lanes can therefore be reordered, duplicated or cleared on the way into an arithmetic unit, and this adds no cycle.

On the result side, a 64-bit result is merged into the previous destination value under a 4-bit lane write mask. Enabled lanes take the result and disabled lanes keep their old contents. The block holds no state. Register storage and the arithmetic units sit outside it.

Top module: `opnd_cond`

## Requirements
- R1: Lane x occupies bits 63:48, y bits 47:32, z bits 31:16 and w bits 15:0. In a swizzle code, the 3-bit selector for output lane x is bits 11:9, for y bits 8:6, for z bits 5:3 and for w bits 2:0. Selector values 0, 1, 2 and 3 copy source lane x, y, z and w respectively.
- R2: Selector value 4 drives a zero into that output lane.
- R3: Selector values 5, 6 and 7 also drive a zero into that output lane.
- R4: One source lane may feed several output lanes in the same word, for example code x,x,z,z.
- R5: Operand B's output depends only on src_b_i and swz_b_i. Changing src_a_i or swz_a_i leaves opnd_b_o unchanged, and the reverse holds for operand A.
- R6: Write mask bit 3 enables lane x, bit 2 lane y, bit 1 lane z and bit 0 lane w, so 4'b1010 enables x and z. An enabled lane of dst_new_o equals the same lane of res_i.
- R7: A lane whose mask bit is 0 carries the same lane of dst_old_i into dst_new_o.
- R8: All outputs are combinational functions of the present inputs, valid in the same cycle with zero latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_i | input | 64 | Source operand A |
| swz_a_i | input | 12 | Swizzle code for operand A, four 3-bit lane selectors |
| src_b_i | input | 64 | Source operand B |
| swz_b_i | input | 12 | Swizzle code for operand B |
| res_i | input | 64 | Result word to be written back |
| dst_old_i | input | 64 | Previous destination register value |
| wmask_i | input | 4 | Lane write enables, MSB = x |
| opnd_a_o | output | 64 | Conditioned operand A |
| opnd_b_o | output | 64 | Conditioned operand B |
| dst_new_o | output | 64 | Merged destination value |

## Verification
The bench targets the lane ordering first. A design with x and w swapped in the word, or in the selector fields, reverses lanes under the identity code 0,1,2,3. It also drives selector values 4 through 7. A design that decodes only the low two bits returns a source lane where a zero is due, and one that zeroes only on value 4 leaks data for 5 to 7. Broadcast codes and mixed mask patterns such as 4'b1010 and 4'b0001 expose a reversed mask bit order and the loss of an unmasked lane. Changes on one operand while the other is held expose crosstalk between the two swizzle paths.

// File: rtl/opnd_cond_pkg.sv
package opnd_cond_pkg;
    localparam int LANE_W_DEF = 16;
    localparam int LANES_DEF  = 4;

    typedef enum logic [2:0] {
        PICK_X    = 3'd0,
        PICK_Y    = 3'd1,
        PICK_Z    = 3'd2,
        PICK_W    = 3'd3,
        PICK_ZERO = 3'd4
    } lane_pick_e;
endpackage

// File: rtl/swz_lane_mux.sv
module swz_lane_mux #(
    parameter int LANE_W = opnd_cond_pkg::LANE_W_DEF,
    parameter int LANES  = opnd_cond_pkg::LANES_DEF,
    localparam int DATA_W = LANE_W * LANES,
    localparam int SEL_W  = $clog2(LANES) + 1
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [LANE_W-1:0] lane_o
);
    logic [LANE_W-1:0] lane_d;

    always_comb begin
        lane_d = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sel_i == SEL_W'(k)) begin
                lane_d = src_i[DATA_W-1-k*LANE_W -: LANE_W];
            end
        end
    end

    assign lane_o = lane_d;

    always_comb begin
        if (sel_i >= SEL_W'(LANES)) begin
            p_zero_code_r2: assert (lane_o == '0)
                else $error("out-of-range selector did not zero the lane (R2/R3)");
        end else begin
            p_pass_code_r1: assert (lane_o == LANE_W'(src_i >> (LANE_W * (LANES - 1 - int'(sel_i)))))
                else $error("selected lane does not match source lane (R1)");
        end
    end
endmodule

// File: rtl/swz_operand.sv
module swz_operand #(
    parameter int LANE_W = opnd_cond_pkg::LANE_W_DEF,
    parameter int LANES  = opnd_cond_pkg::LANES_DEF,
    localparam int DATA_W = LANE_W * LANES,
    localparam int SEL_W  = $clog2(LANES) + 1,
    localparam int CODE_W = SEL_W * LANES
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] opnd_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        swz_lane_mux #(
            .LANE_W (LANE_W),
            .LANES  (LANES)
        ) u_mux (
            .src_i  (src_i),
            .sel_i  (code_i[CODE_W-1-i*SEL_W -: SEL_W]),
            .lane_o (opnd_o[DATA_W-1-i*LANE_W -: LANE_W])
        );
    end
endmodule

// File: rtl/wb_merge.sv
module wb_merge #(
    parameter int LANE_W = opnd_cond_pkg::LANE_W_DEF,
    parameter int LANES  = opnd_cond_pkg::LANES_DEF,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] old_i,
    input  logic [LANES-1:0]  mask_i,
    output logic [DATA_W-1:0] dst_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HI = DATA_W - 1 - i * LANE_W;
        logic [LANE_W-1:0] lane_d;

        always_comb begin
            lane_d = old_i[HI -: LANE_W];
            if (mask_i[LANES-1-i]) begin
                lane_d = res_i[HI -: LANE_W];
            end
        end

        assign dst_o[HI -: LANE_W] = lane_d;

        always_comb begin
            if (mask_i[LANES-1-i]) begin
                p_take_lane_r6: assert (dst_o[HI -: LANE_W] == res_i[HI -: LANE_W])
                    else $error("enabled lane did not take the result (R6)");
            end else begin
                p_keep_lane_r7: assert (dst_o[HI -: LANE_W] == old_i[HI -: LANE_W])
                    else $error("disabled lane lost its old value (R7)");
            end
        end
    end
endmodule

// File: rtl/opnd_cond.sv
module opnd_cond #(
    parameter int LANE_W = opnd_cond_pkg::LANE_W_DEF,
    parameter int LANES  = opnd_cond_pkg::LANES_DEF,
    localparam int DATA_W = LANE_W * LANES,
    localparam int SEL_W  = $clog2(LANES) + 1,
    localparam int CODE_W = SEL_W * LANES,
    localparam int NSRC   = 2
) (
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [CODE_W-1:0] swz_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [CODE_W-1:0] swz_b_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] dst_old_i,
    input  logic [LANES-1:0]  wmask_i,
    output logic [DATA_W-1:0] opnd_a_o,
    output logic [DATA_W-1:0] opnd_b_o,
    output logic [DATA_W-1:0] dst_new_o
);
    typedef struct packed {
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic [DATA_W-1:0] dst;
    } cond_out_t;

    logic [DATA_W-1:0] src_arr  [NSRC];
    logic [CODE_W-1:0] code_arr [NSRC];
    logic [DATA_W-1:0] opnd_arr [NSRC];
    logic [DATA_W-1:0] merged;
    cond_out_t         out_d;

    assign src_arr[0]  = src_a_i;
    assign src_arr[1]  = src_b_i;
    assign code_arr[0] = swz_a_i;
    assign code_arr[1] = swz_b_i;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        swz_operand #(
            .LANE_W (LANE_W),
            .LANES  (LANES)
        ) u_swz (
            .src_i  (src_arr[s]),
            .code_i (code_arr[s]),
            .opnd_o (opnd_arr[s])
        );
    end

    wb_merge #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_merge (
        .res_i  (res_i),
        .old_i  (dst_old_i),
        .mask_i (wmask_i),
        .dst_o  (merged)
    );

    always_comb begin
        out_d.opa = opnd_arr[0];
        out_d.opb = opnd_arr[1];
        out_d.dst = merged;
    end

    assign opnd_a_o  = out_d.opa;
    assign opnd_b_o  = out_d.opb;
    assign dst_new_o = out_d.dst;

    always_comb begin
        if (wmask_i == '0) begin
            p_mask_clear_r7: assert (dst_new_o == dst_old_i)
                else $error("empty mask altered destination (R7)");
        end
        if (wmask_i == '1) begin
            p_mask_full_r6: assert (dst_new_o == res_i)
                else $error("full mask did not write whole result (R6)");
        end
    end
endmodule

// File: tb/opnd_cond_test.sv
module opnd_cond_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_a, src_b, res, dst_old;
    logic [11:0] swz_a, swz_b;
    logic [3:0]  wmask;
    logic [63:0] opnd_a, opnd_b, dst_new;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    opnd_cond uut (
        .src_a_i   (src_a),
        .swz_a_i   (swz_a),
        .src_b_i   (src_b),
        .swz_b_i   (swz_b),
        .res_i     (res),
        .dst_old_i (dst_old),
        .wmask_i   (wmask),
        .opnd_a_o  (opnd_a),
        .opnd_b_o  (opnd_b),
        .dst_new_o (dst_new)
    );

    function automatic logic [63:0] ref_swz(logic [63:0] s, logic [11:0] c);
        logic [63:0] r = 64'd0;
        for (int o = 0; o < 4; o++) begin
            int code = int'((c >> (9 - 3 * o)) & 12'h7);
            longint unsigned v = 0;
            if (code < 4) v = (s >> (48 - 16 * code)) & 64'hFFFF;
            r = r | (64'(v) << (48 - 16 * o));
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_merge(logic [63:0] r, logic [63:0] d, logic [3:0] m);
        logic [63:0] q = d;
        for (int o = 0; o < 4; o++) begin
            logic [63:0] lm = 64'hFFFF << (48 - 16 * o);
            if (m[3 - o]) q = (q & ~lm) | (r & lm);
        end
        return q;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive just after a rising edge, sample at the following falling edge:
    // no register stands between inputs and outputs (R8).
    task automatic apply(logic [63:0] sa, logic [11:0] ca, logic [63:0] sb, logic [11:0] cb,
                         logic [63:0] r, logic [63:0] d, logic [3:0] m,
                         string ra, string rb, string rd);
        @(posedge clk);
        #1;
        src_a = sa; swz_a = ca; src_b = sb; swz_b = cb;
        res = r; dst_old = d; wmask = m;
        @(negedge clk);
        check(ra, "opnd_a", opnd_a, ref_swz(sa, ca));
        check(rb, "opnd_b", opnd_b, ref_swz(sb, cb));
        check(rd, "dst_new", dst_new, ref_merge(r, d, m));
    endtask

    function automatic logic [11:0] code4(int x, int y, int z, int w);
        return {3'(x), 3'(y), 3'(z), 3'(w)};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v  = 64'h1111_2222_3333_4444;
        logic [63:0] v2 = 64'hAAAA_BBBB_CCCC_DDDD;
        src_a = '0; src_b = '0; res = '0; dst_old = '0;
        swz_a = '0; swz_b = '0; wmask = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8", "idle opnd_a", opnd_a, 64'd0);
        check("R8", "idle dst_new", dst_new, 64'd0);

        // R1 identity and reversal
        apply(v, code4(0,1,2,3), v2, code4(3,2,1,0), 64'h0, 64'h0, 4'h0, "R1", "R1", "R7");
        check("R1", "identity literal", opnd_a, 64'h1111_2222_3333_4444);
        check("R1", "reverse literal", opnd_b, 64'hDDDD_CCCC_BBBB_AAAA);
        // R2 zero code
        apply(v, code4(4,1,4,3), v, code4(4,4,4,4), 64'h0, 64'h0, 4'h0, "R2", "R2", "R7");
        check("R2", "zero lanes literal", opnd_a, 64'h0000_2222_0000_4444);
        // R3 codes 5..7
        apply(v, code4(5,6,7,0), v, code4(7,7,7,7), 64'h0, 64'h0, 4'h0, "R3", "R3", "R7");
        check("R3", "high codes literal", opnd_a, 64'h0000_0000_0000_1111);
        // R4 duplication
        apply(v, code4(0,0,2,2), v, code4(1,1,1,1), 64'h0, 64'h0, 4'h0, "R4", "R4", "R7");
        check("R4", "duplicate literal", opnd_a, 64'h1111_1111_3333_3333);
        check("R4", "broadcast literal", opnd_b, 64'h2222_2222_2222_2222);
        // R6 / R7 mask patterns
        apply(v, code4(0,1,2,3), v, code4(0,1,2,3), v2, v, 4'b1010, "R1", "R1", "R6");
        check("R6", "mask 1010 literal", dst_new, 64'hAAAA_2222_CCCC_4444);
        apply(v, code4(0,1,2,3), v, code4(0,1,2,3), v2, v, 4'b0001, "R1", "R1", "R6");
        check("R6", "mask 0001 literal", dst_new, 64'h1111_2222_3333_DDDD);
        apply(v, code4(0,1,2,3), v, code4(0,1,2,3), v2, v, 4'b0000, "R1", "R1", "R7");
        check("R7", "mask 0000 literal", dst_new, v);
        apply(v, code4(0,1,2,3), v, code4(0,1,2,3), v2, v, 4'b1111, "R1", "R1", "R6");
        check("R6", "mask 1111 literal", dst_new, v2);

        // R5: hold operand B, vary operand A; then the reverse
        for (int i = 0; i < 16; i++) begin
            apply({$urandom, $urandom}, 12'($urandom), v2, code4(3,0,4,1),
                  64'h0, 64'h0, 4'h0, "R5", "R5", "R7");
            check("R5", "opnd_b held", opnd_b, 64'hDDDD_AAAA_0000_BBBB);
        end
        for (int i = 0; i < 16; i++) begin
            apply(v, code4(2,6,0,3), {$urandom, $urandom}, 12'($urandom),
                  64'h0, 64'h0, 4'h0, "R5", "R5", "R7");
            check("R5", "opnd_a held", opnd_a, 64'h3333_0000_1111_4444);
        end

        // Broad sweep: every cycle compared with the behavioural model
        for (int i = 0; i < 300; i++) begin
            apply({$urandom, $urandom}, 12'($urandom), {$urandom, $urandom}, 12'($urandom),
                  {$urandom, $urandom}, {$urandom, $urandom}, 4'($urandom),
                  "R1", "R5", "R6");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule